// File: doc/BRIEF.md
# Packet Common Header Extractor

This block sits on the receive path behind the transport layer. Each packet arrives on a 64-bit streaming sink with its most significant byte first. The first four bytes of every packet form a radio common header. The block takes that header off the front of the packet and decodes it into sideband fields: direction, filter index, frame, subframe, slot and symbol numbers. The rest of the packet is shifted so that the first payload byte lands in the top byte lane of the first output word.

Because the header fills exactly the upper half of the start word, the payload stream is built from two sources. The lower half of the previous input word supplies the top of each output word, and the upper half of the current input word supplies the bottom. Packet end handling follows from this. A short last input word can close the output packet on the same beat. A longer one needs one extra flush beat, and the sink is stalled while that beat is pending. The control/user plane flag and the error indication are carried from input to output. A header version other than the expected one marks the packet as bad.

Top module: `cmh_extractor`

## Requirements
- R1: After reset, out_valid and hdr_short are 0 and in_ready is 1.
- R2: On an accepted start beat, in_data[63:32] is decoded as the header, most significant bit first: bit 63 direction, bits 62:60 version, 59:56 filter index, 55:48 frame, 47:44 subframe, 43:38 slot, 37:32 symbol. The decoded fields hold their value on every beat of that packet's output.
- R3: A start beat produces no output beat of its own. Each later input beat produces the output word {previous input word [31:0], current input word [63:32]}. The first output beat of a packet carries out_sop = 1.
- R4: When the last input beat has in_empty of 4 or more, the output packet ends on that same beat with out_empty = in_empty - 4. out_empty is 0 on every beat that is not an end beat.
- R5: When the last input beat has in_empty below 4, the output produces one more beat {last input word [31:0], 32'h0}, with out_eop = 1 and out_empty = in_empty + 4. in_ready stays 0 while that beat is waiting.
- R6: An in_err that is set on the last input beat appears as out_err on the output end beat, and on no other beat.
- R7: A header whose version field differs from VER_EXPECT (default 1) sets out_err on the output end beat of that packet.
- R8: A packet that consists of one beat with both start and end set and in_empty of 4 or more produces no output beat. It raises hdr_short for exactly one cycle.
- R9: While out_valid = 1 and out_ready = 0, in_ready stays 0 for a packet in progress and out_data holds its value. Under backpressure, the payload delivered is the same as without it.
- R10: The plane flag in_ctrl is sampled on the start beat and appears on out_ctrl for every output beat of that packet.
- R11: A single start+end beat with in_empty below 4 produces one output beat {in_data[31:0], 32'h0} with out_sop and out_eop both set and out_empty = in_empty + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sink word valid |
| in_ready | output | 1 | Sink can accept (latency 0) |
| in_data | input | 64 | Sink word, first byte in bits 63:56 |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_empty | input | 3 | Unused bytes in last word |
| in_err | input | 1 | Packet error, valid with in_eop |
| in_ctrl | input | 1 | Plane flag, 1 for control |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 64 | Realigned payload word |
| out_sop | output | 1 | First payload word |
| out_eop | output | 1 | Last payload word |
| out_empty | output | 3 | Unused bytes in last payload word |
| out_err | output | 1 | Packet error at out_eop |
| out_ctrl | output | 1 | Plane flag of current packet |
| hdr_dir | output | 1 | Decoded direction |
| hdr_filter | output | 4 | Decoded filter index |
| hdr_frame | output | 8 | Decoded frame number |
| hdr_subframe | output | 4 | Decoded subframe number |
| hdr_slot | output | 6 | Decoded slot number |
| hdr_symbol | output | 6 | Decoded symbol number |
| hdr_short | output | 1 | One-cycle pulse for a header-only packet |

## Verification
The bench builds the block with its default VER_EXPECT of 1. It therefore reaches both a version that passes (1) and one that fails (2) simply by changing the header field. The 64-bit word with a 3-bit empty count lets the bench sweep all eight empty values of a two-word packet. That sweep reaches both the same-beat end and the flush-beat end, including the boundary between empty 3 and empty 4. Alternating out_ready during a four-word packet stalls both mid-packet words and the flush word.

// File: rtl/cmh_pkg.sv
package cmh_pkg;
    localparam int WORD_W     = 64;
    localparam int BYTES      = WORD_W / 8;
    localparam int HALF_W     = WORD_W / 2;
    localparam int HALF_BYTES = BYTES / 2;
    localparam int EMPTY_W    = $clog2(BYTES);

    // Header layout, most significant bit first on the wire.
    typedef struct packed {
        logic       dir;
        logic [2:0] ver;
        logic [3:0] filt;
        logic [7:0] frame;
        logic [3:0] sub;
        logic [5:0] slot;
        logic [5:0] sym;
    } chdr_t;

    // Empty count after the stream has been shifted by half a word.
    function automatic logic [EMPTY_W-1:0] shift_empty(input logic [EMPTY_W-1:0] e);
        return e + EMPTY_W'(HALF_BYTES);
    endfunction

    // True when the last word's valid bytes fit in the held half.
    function automatic logic tail_fits(input logic [EMPTY_W-1:0] e);
        return e >= EMPTY_W'(HALF_BYTES);
    endfunction
endpackage

// File: rtl/cmh_hdr_latch.sv
module cmh_hdr_latch
    import cmh_pkg::*;
#(
    parameter logic [2:0] VER_EXPECT = 3'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HALF_W-1:0] hdr_word,
    input  logic              ctrl_in,
    output chdr_t             hdr_q,
    output logic              ctrl_q,
    output logic              ver_bad_now,
    output logic              ver_bad_q
);
    chdr_t hdr_now;

    always_comb begin
        hdr_now     = chdr_t'(hdr_word);
        ver_bad_now = (hdr_now.ver != VER_EXPECT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q     <= '0;
            ctrl_q    <= 1'b0;
            ver_bad_q <= 1'b0;
        end else if (load) begin
            hdr_q     <= hdr_now;
            ctrl_q    <= ctrl_in;
            ver_bad_q <= ver_bad_now;
        end
    end
endmodule

// File: rtl/cmh_realign.sv
module cmh_realign
    import cmh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_err,
    input  logic               ver_bad_now,
    input  logic               ver_bad_q,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_err,
    output logic               hdr_load,
    output logic               short_pulse
);
    logic               in_pkt;
    logic               first_out;
    logic [HALF_W-1:0]  hold_lo;
    logic               flush_pend;
    logic [EMPTY_W-1:0] flush_empty;
    logic               flush_err;

    logic fire_in, mid, tail_here;

    always_comb begin
        in_ready  = !flush_pend && (in_sop || !in_pkt || out_ready);
        fire_in   = in_valid && in_ready;
        mid       = in_valid && in_pkt && !in_sop;
        tail_here = mid && in_eop && tail_fits(in_empty);
        hdr_load  = fire_in && in_sop;

        out_valid = flush_pend || mid;
        out_sop   = first_out;
        out_eop   = flush_pend || tail_here;
        if (flush_pend) begin
            out_data  = {hold_lo, {HALF_W{1'b0}}};
            out_empty = flush_empty;
            out_err   = flush_err;
        end else begin
            out_data  = {hold_lo, in_data[WORD_W-1:HALF_W]};
            out_empty = tail_here ? shift_empty(in_empty) : '0;
            out_err   = tail_here && (in_err || ver_bad_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt      <= 1'b0;
            first_out   <= 1'b0;
            hold_lo     <= '0;
            flush_pend  <= 1'b0;
            flush_empty <= '0;
            flush_err   <= 1'b0;
            short_pulse <= 1'b0;
        end else begin
            short_pulse <= 1'b0;
            if (flush_pend && out_ready) begin
                flush_pend <= 1'b0;
                first_out  <= 1'b0;
            end
            if (fire_in) begin
                hold_lo <= in_data[HALF_W-1:0];
                if (in_sop) begin
                    first_out <= 1'b1;
                    in_pkt    <= !in_eop;
                    if (in_eop) begin
                        if (tail_fits(in_empty)) begin
                            short_pulse <= 1'b1;
                            first_out   <= 1'b0;
                        end else begin
                            flush_pend  <= 1'b1;
                            flush_empty <= shift_empty(in_empty);
                            flush_err   <= in_err || ver_bad_now;
                        end
                    end
                end else if (in_pkt) begin
                    first_out <= 1'b0;
                    if (in_eop) begin
                        in_pkt <= 1'b0;
                        if (!tail_fits(in_empty)) begin
                            flush_pend  <= 1'b1;
                            flush_empty <= shift_empty(in_empty);
                            flush_err   <= in_err || ver_bad_q;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cmh_extractor.sv
module cmh_extractor
    import cmh_pkg::*;
#(
    parameter logic [2:0] VER_EXPECT = 3'd1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_err,
    input  logic               in_ctrl,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_err,
    output logic               out_ctrl,
    output logic               hdr_dir,
    output logic [3:0]         hdr_filter,
    output logic [7:0]         hdr_frame,
    output logic [3:0]         hdr_subframe,
    output logic [5:0]         hdr_slot,
    output logic [5:0]         hdr_symbol,
    output logic               hdr_short
);
    chdr_t hdr_q;
    logic  hdr_load, ver_bad_now, ver_bad_q;

    cmh_hdr_latch #(.VER_EXPECT(VER_EXPECT)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .load       (hdr_load),
        .hdr_word   (in_data[WORD_W-1:HALF_W]),
        .ctrl_in    (in_ctrl),
        .hdr_q      (hdr_q),
        .ctrl_q     (out_ctrl),
        .ver_bad_now(ver_bad_now),
        .ver_bad_q  (ver_bad_q)
    );

    cmh_realign u_align (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_empty   (in_empty),
        .in_err     (in_err),
        .ver_bad_now(ver_bad_now),
        .ver_bad_q  (ver_bad_q),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_empty  (out_empty),
        .out_err    (out_err),
        .hdr_load   (hdr_load),
        .short_pulse(hdr_short)
    );

    assign hdr_dir      = hdr_q.dir;
    assign hdr_filter   = hdr_q.filt;
    assign hdr_frame    = hdr_q.frame;
    assign hdr_subframe = hdr_q.sub;
    assign hdr_slot     = hdr_q.slot;
    assign hdr_symbol   = hdr_q.sym;
endmodule

// File: rtl/cmh_checker.sv
module cmh_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_sop,
    input logic        in_eop,
    input logic [2:0]  in_empty,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic [2:0]  out_empty,
    input logic        out_ctrl,
    input logic [7:0]  hdr_frame,
    input logic [5:0]  hdr_slot,
    input logic        hdr_short
);
    p_fields_stable_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_sop |-> $stable(hdr_frame) && $stable(hdr_slot) && $stable(out_ctrl));

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_eop |-> out_empty == 3'd0);

    p_flush_beat_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_sop && in_eop && in_empty < 3'd4 && out_valid
        |=> out_valid && out_eop && !in_ready && out_empty == $past(in_empty) + 3'd4);

    p_short_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        hdr_short |=> !hdr_short);

    p_short_silent_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_sop && in_eop && in_empty >= 3'd4 |=> !out_valid && hdr_short);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind cmh_extractor cmh_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_empty (in_empty),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_empty(out_empty),
    .out_ctrl (out_ctrl),
    .hdr_frame(hdr_frame),
    .hdr_slot (hdr_slot),
    .hdr_short(hdr_short)
);

// File: tb/cmh_extractor_test.sv
module cmh_extractor_test;
    localparam int P = 10;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0, in_ctrl = 0, out_ready = 1;
    logic [63:0] in_data = '0;
    logic [2:0]  in_empty = '0;
    logic in_ready, out_valid, out_sop, out_eop, out_err, out_ctrl, hdr_dir, hdr_short;
    logic [63:0] out_data;
    logic [2:0]  out_empty;
    logic [3:0]  hdr_filter, hdr_subframe;
    logic [7:0]  hdr_frame;
    logic [5:0]  hdr_slot, hdr_symbol;

    cmh_extractor uut (.*);

    always #(P/2) clk = ~clk;

    int checks = 0, fails = 0, nrec = 0, short_cnt = 0;
    logic bp = 0, stall_prev = 0;
    logic [63:0] stall_data;
    logic [63:0] r_data [32];
    logic        r_sop [32], r_eop [32], r_err [32], r_ctrl [32];
    logic [2:0]  r_empty [32];
    logic [31:0] r_hdr [32];

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(input logic d, input logic [2:0] v, input logic [3:0] f,
                                          input logic [7:0] fr, input logic [3:0] sf,
                                          input logic [5:0] sl, input logic [5:0] sy);
        return {d, v, f, fr, sf, sl, sy};
    endfunction

    task automatic smp();
        if (stall_prev) chk(out_valid && out_data == stall_data, "R9", out_data, stall_data);
        stall_prev = out_valid && !out_ready;
        stall_data = out_data;
        if (out_valid && out_ready && nrec < 32) begin
            r_data[nrec] = out_data; r_sop[nrec] = out_sop; r_eop[nrec] = out_eop;
            r_err[nrec] = out_err; r_ctrl[nrec] = out_ctrl; r_empty[nrec] = out_empty;
            r_hdr[nrec] = {hdr_dir, 3'd0, hdr_filter, hdr_frame, hdr_subframe, hdr_slot, hdr_symbol};
            nrec++;
        end
        if (hdr_short) short_cnt++;
    endtask

    task automatic step();
        #(P/4); smp();
        @(posedge clk); @(negedge clk);
        out_ready = bp ? ~out_ready : 1'b1;
    endtask

    task automatic put(input logic [63:0] d, input logic s, input logic e, input logic [2:0] em,
                       input logic er, input logic c);
        logic acc = 0;
        in_valid = 1; in_data = d; in_sop = s; in_eop = e; in_empty = em; in_err = er; in_ctrl = c;
        while (!acc) begin
            #(P/4); acc = in_ready; smp();
            @(posedge clk); @(negedge clk);
            out_ready = bp ? ~out_ready : 1'b1;
        end
        in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) step();
    endtask

    task automatic t_reset();
        #(P/4);
        chk(!out_valid && in_ready && !hdr_short, "R1", {out_valid, in_ready, hdr_short}, 3'b010);
    endtask

    // Three-word control packet, last word with two valid bytes.
    task automatic t_multi();
        logic [31:0] h = mkhdr(1, 1, 4'h9, 8'hA5, 4'h6, 6'h2B, 6'h11);
        logic [63:0] b = 64'h1111_2222_3333_4444, c = 64'h5566_0000_0000_0000;
        nrec = 0;
        put({h, 32'hAAAA_BBBB}, 1, 0, 0, 0, 1);
        put(b, 0, 0, 0, 0, 1);
        put(c, 0, 1, 6, 0, 1);
        drain();
        chk(nrec == 2, "R3", nrec, 2);
        chk(r_data[0] == {32'hAAAA_BBBB, b[63:32]} && r_sop[0] && !r_eop[0], "R3", r_data[0], {32'hAAAA_BBBB, b[63:32]});
        chk(r_data[1] == {b[31:0], c[63:32]} && !r_sop[1], "R3", r_data[1], {b[31:0], c[63:32]});
        chk(r_eop[1] && r_empty[1] == 2 && r_empty[0] == 0, "R4", r_empty[1], 2);
        chk(r_hdr[0] == (h & 32'h8FFF_FFFF) && r_hdr[1] == r_hdr[0], "R2", r_hdr[1], h & 32'h8FFF_FFFF);
        chk(r_ctrl[0] && r_ctrl[1], "R10", {r_ctrl[0], r_ctrl[1]}, 2'b11);
        chk(!r_err[1], "R7", r_err[1], 0);
    endtask

    // Two-word packets over every end empty count.
    task automatic t_sweep();
        logic [63:0] b = 64'hC0C1_C2C3_C4C5_C6C7;
        for (int e = 0; e < 8; e++) begin
            nrec = 0;
            put({mkhdr(0, 1, 1, 8'(e), 2, 3, 4), 32'hDEAD_0000 | e}, 1, 0, 0, 0, 0);
            put(b, 0, 1, 3'(e), 0, 0);
            if (e < 4) begin
                #(P/4);
                chk(!in_ready && out_valid && out_eop, "R5", {in_ready, out_valid, out_eop}, 3'b011);
            end
            drain();
            if (e >= 4) begin
                chk(nrec == 1 && r_eop[0] && r_sop[0] && r_empty[0] == 3'(e - 4), "R4", r_empty[0], e - 4);
                chk(r_data[0] == {32'hDEAD_0000 | e, b[63:32]}, "R3", r_data[0], {32'hDEAD_0000 | e, b[63:32]});
            end else begin
                chk(nrec == 2 && !r_eop[0] && r_eop[1] && r_empty[1] == 3'(e + 4), "R5", r_empty[1], e + 4);
                chk(r_data[1] == {b[31:0], 32'h0}, "R5", r_data[1], {b[31:0], 32'h0});
            end
            chk(r_hdr[0][23:16] == 8'(e), "R2", r_hdr[0][23:16], e);
        end
    endtask

    task automatic t_err();
        nrec = 0;
        put({mkhdr(0, 1, 0, 1, 0, 0, 0), 32'h1}, 1, 0, 0, 0, 0);
        put(64'h2, 0, 0, 0, 0, 0);
        put(64'h3, 0, 1, 5, 1, 0);
        drain();
        chk(nrec == 2 && !r_err[0] && r_err[1], "R6", {r_err[0], r_err[1]}, 2'b01);
        nrec = 0;
        put({mkhdr(0, 1, 0, 1, 0, 0, 0), 32'h1}, 1, 0, 0, 0, 0);
        put(64'h3, 0, 1, 2, 1, 0);
        drain();
        chk(nrec == 2 && !r_err[0] && r_err[1], "R6", {r_err[0], r_err[1]}, 2'b01);
    endtask

    task automatic t_version();
        nrec = 0;
        put({mkhdr(0, 2, 0, 7, 0, 0, 0), 32'h1}, 1, 0, 0, 0, 0);
        put(64'h3, 0, 1, 4, 0, 0);
        drain();
        chk(nrec == 1 && r_err[0], "R7", r_err[0], 1);
        nrec = 0;
        put({mkhdr(0, 0, 0, 7, 0, 0, 0), 32'h1}, 1, 0, 0, 0, 0);
        put(64'h3, 0, 1, 1, 0, 0);
        drain();
        chk(nrec == 2 && !r_err[0] && r_err[1], "R7", {r_err[0], r_err[1]}, 2'b01);
    endtask

    task automatic t_short();
        nrec = 0; short_cnt = 0;
        put({mkhdr(1, 1, 2, 3, 4, 5, 6), 32'h0}, 1, 1, 4, 0, 0);
        drain();
        chk(nrec == 0 && short_cnt == 1, "R8", {nrec[7:0], short_cnt[7:0]}, 16'h0001);
    endtask

    task automatic t_single();
        nrec = 0; short_cnt = 0;
        put({mkhdr(1, 1, 2, 3, 4, 5, 6), 32'h7788_99AA}, 1, 1, 1, 0, 0);
        drain();
        chk(nrec == 1 && r_sop[0] && r_eop[0] && r_empty[0] == 5, "R11", {r_sop[0], r_eop[0], r_empty[0]}, 5'b11101);
        chk(r_data[0] == {32'h7788_99AA, 32'h0} && short_cnt == 0, "R11", r_data[0], {32'h7788_99AA, 32'h0});
    endtask

    task automatic t_backpressure();
        logic [63:0] w [4];
        w[0] = {mkhdr(0, 1, 3, 9, 1, 1, 1), 32'h0102_0304};
        w[1] = 64'h1112_1314_1516_1718; w[2] = 64'h2122_2324_2526_2728; w[3] = 64'h3132_3334_3536_3738;
        nrec = 0; bp = 1; out_ready = 0;
        put(w[0], 1, 0, 0, 0, 0);
        put(w[1], 0, 0, 0, 0, 0);
        put(w[2], 0, 0, 0, 0, 0);
        put(w[3], 0, 1, 0, 0, 0);
        for (int i = 0; i < 6; i++) step();
        bp = 0; out_ready = 1; drain();
        chk(nrec == 4, "R9", nrec, 4);
        for (int i = 0; i < 3; i++)
            chk(r_data[i] == {w[i][31:0], w[i+1][63:32]}, "R9", r_data[i], {w[i][31:0], w[i+1][63:32]});
        chk(r_data[3] == {w[3][31:0], 32'h0} && r_eop[3] && r_empty[3] == 4, "R9", r_data[3], {w[3][31:0], 32'h0});
    endtask

    initial begin
        #(P * 100000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        @(negedge clk); rst = 0; @(negedge clk);
        t_multi();
        t_sweep();
        t_err();
        t_version();
        t_short();
        t_single();
        t_backpressure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule